// File: doc/BRIEF.md
# Predicated Element Issue Loop

This block sequences one vectorised operation as a stream of element operations, one per clock cycle. A start strobe supplies the destination register number and a vector length. The block uses the destination register number as a key into a small internal predication table. A matching entry names the integer register that holds the predicate mask, and may call for the mask to be complemented. The block reads that register through a narrow read port in the start cycle and holds the resulting mask for the whole loop.

Each issued element carries its index, an enable bit and a zero-write bit. An element whose mask bit is clear still takes its cycle slot. Depending on the entry's zeroing mode, that element is either skipped (both bits low) or marked for a zero write. Lanes at or above the vector length count as masked. The register file and the ALU that consume the stream sit outside the block.

Top module: `pred_issue_loop`

## Requirements
- R1: A start's register number is looked up against the key of every valid table entry. On a match, `mask_raddr` carries the entry's predicate register number in the same cycle as the start, and the mask is taken from `mask_rdata` at that clock edge.
- R2: An entry with its invert flag set complements all mask bits before use.
- R3: With an entry's zeroing mode set, an element whose effective mask bit is 0 issues with `iss_en`=0 and `iss_zero`=1.
- R4: With zeroing mode clear, an element whose mask bit is 0 issues with `iss_en`=0 and `iss_zero`=0 and still occupies one cycle. Indices issue as 0,1,2,... with no gaps. Bit i of the mask governs element i.
- R5: A register number with no matching valid entry enables every element below the vector length, and no element carries `iss_zero`.
- R6: When several valid entries share a key, the entry at the highest table index decides. An entry written with its valid bit clear never matches.
- R7: The vector length is clamped to XLEN (32 by default). A start with length 0 issues nothing, and `busy` stays low.
- R8: An accepted start raises `busy` at the next edge, and element 0 appears in that cycle. `busy` falls after element VL-1 has been shown for one cycle. A start that arrives while `busy` is high is ignored.
- R9: Table writes made while a loop runs do not alter the enable or zero bits of that loop's elements.
- R10: After reset, `busy`, `iss_valid`, `iss_en` and `iss_zero` are 0 and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_sel | input | 4 | Table entry index to write |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_key | input | 5 | Register number the entry matches |
| tbl_preg | input | 5 | Integer register holding the mask |
| tbl_inv | input | 1 | Complement the mask |
| tbl_zero | input | 1 | Zeroing mode for masked elements |
| start | input | 1 | Start strobe |
| start_rd | input | 5 | Destination register number (lookup key) |
| start_vl | input | 6 | Vector length |
| mask_raddr | output | 5 | Read address to the integer register file |
| mask_rdata | input | 32 | Register contents returned for `mask_raddr` |
| busy | output | 1 | Loop in progress |
| iss_valid | output | 1 | An element is issued this cycle |
| iss_idx | output | 5 | Index of the issued element |
| iss_en | output | 1 | Element executes |
| iss_zero | output | 1 | Element writes zero to its destination |

## Verification
The hardest case to reach is the one where the table or the start inputs change while a loop is running. The stimulus first starts a long loop. Partway through, at a known element index, it pulses a fresh start with a different register number and rewrites the very entry the loop was keyed on. The element stream is then compared, element by element, against the mask captured at the original start. Shared keys are provoked by writing a second entry at a higher index with the same key, and then writing that entry invalid to show that the lower entry takes over again.

// File: rtl/pred_issue_loop.sv
module pred_issue_loop #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NENT = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tbl_we,
  input  logic [$clog2(NENT)-1:0]      tbl_sel,
  input  logic                         tbl_valid,
  input  logic [$clog2(NREG)-1:0]      tbl_key,
  input  logic [$clog2(NREG)-1:0]      tbl_preg,
  input  logic                         tbl_inv,
  input  logic                         tbl_zero,
  input  logic                         start,
  input  logic [$clog2(NREG)-1:0]      start_rd,
  input  logic [$clog2(XLEN+1)-1:0]    start_vl,
  output logic [$clog2(NREG)-1:0]      mask_raddr,
  input  logic [XLEN-1:0]              mask_rdata,
  output logic                         busy,
  output logic                         iss_valid,
  output logic [$clog2(XLEN)-1:0]      iss_idx,
  output logic                         iss_en,
  output logic                         iss_zero
);
  localparam int RW  = $clog2(NREG);
  localparam int VLW = $clog2(XLEN+1);
  localparam int IW  = $clog2(XLEN);

  logic [NENT-1:0] ent_v, ent_inv, ent_zero;
  logic [RW-1:0]   ent_key  [NENT];
  logic [RW-1:0]   ent_preg [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_inv  <= '0;
      ent_zero <= '0;
      for (int i = 0; i < NENT; i++) begin
        ent_key[i]  <= '0;
        ent_preg[i] <= '0;
      end
    end else if (tbl_we) begin
      ent_v[tbl_sel]    <= tbl_valid;
      ent_inv[tbl_sel]  <= tbl_inv;
      ent_zero[tbl_sel] <= tbl_zero;
      ent_key[tbl_sel]  <= tbl_key;
      ent_preg[tbl_sel] <= tbl_preg;
    end
  end

  logic          hit, hit_inv, hit_zero;
  logic [RW-1:0] hit_preg;

  always_comb begin
    hit = 1'b0; hit_inv = 1'b0; hit_zero = 1'b0; hit_preg = '0;
    for (int i = 0; i < NENT; i++) begin
      if (ent_v[i] && ent_key[i] == start_rd) begin
        hit      = 1'b1;
        hit_inv  = ent_inv[i];
        hit_zero = ent_zero[i];
        hit_preg = ent_preg[i];
      end
    end
  end

  assign mask_raddr = hit_preg;

  logic [VLW-1:0]  vl_eff, vl_m1;
  logic [XLEN-1:0] lane_lim, mask_sel;

  assign vl_eff = (start_vl > VLW'(XLEN)) ? VLW'(XLEN) : start_vl;
  assign vl_m1  = vl_eff - VLW'(1);

  always_comb begin
    for (int i = 0; i < XLEN; i++) lane_lim[i] = (i < int'(vl_eff));
  end

  assign mask_sel = (hit ? (hit_inv ? ~mask_rdata : mask_rdata) : '1) & lane_lim;

  logic            accept, zero_q;
  logic [XLEN-1:0] mask_q;
  logic [IW-1:0]   idx_q, last_q;

  assign accept = start && !busy && (vl_eff != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      zero_q <= 1'b0;
      mask_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      zero_q <= hit && hit_zero;
      mask_q <= mask_sel;
      idx_q  <= '0;
      last_q <= vl_m1[IW-1:0];
    end else if (busy) begin
      if (idx_q == last_q) busy <= 1'b0;
      else                 idx_q <= idx_q + IW'(1);
    end
  end

  assign iss_valid = busy;
  assign iss_idx   = idx_q;
  assign iss_en    = busy && mask_q[idx_q];
  assign iss_zero  = busy && zero_q && !mask_q[idx_q];
endmodule

// File: rtl/pred_issue_loop_chk.sv
module pred_issue_loop_chk #(
  parameter int XLEN = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    iss_valid,
  input logic [$clog2(XLEN)-1:0] iss_idx,
  input logic                    iss_en,
  input logic                    iss_zero
);
  localparam int IW = $clog2(XLEN);

  assert_en_zero_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_en && iss_zero));

  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (!iss_en && !iss_zero));

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid)) |-> iss_idx == $past(iss_idx) + IW'(1));

  assert_first_elem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (iss_idx == '0));

  assert_valid_is_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid == busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && iss_idx != '0) |=> (!busy || iss_idx == $past(iss_idx) + IW'(1)));
endmodule

bind pred_issue_loop pred_issue_loop_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .iss_valid(iss_valid),
  .iss_idx(iss_idx), .iss_en(iss_en), .iss_zero(iss_zero)
);

// File: tb/sim_pred_issue_loop.sv
module sim_pred_issue_loop;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 0, tbl_valid = 0, tbl_inv = 0, tbl_zero = 0, start = 0;
  logic [3:0] tbl_sel = '0;
  logic [4:0] tbl_key = '0, tbl_preg = '0, start_rd = '0, mask_raddr;
  logic [5:0] start_vl = '0;
  logic [31:0] mask_rdata;
  logic busy, iss_valid, iss_en, iss_zero;
  logic [4:0] iss_idx;

  logic [31:0] iregs [32];
  logic sv [16], sinv [16], szero [16];
  logic [4:0] skey [16], spreg [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign mask_rdata = iregs[mask_raddr];

  pred_issue_loop u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input bit v, input int key, input int preg,
                    input bit inv, input bit z);
    @(negedge clk);
    tbl_we = 1; tbl_sel = 4'(sel); tbl_valid = v; tbl_key = 5'(key);
    tbl_preg = 5'(preg); tbl_inv = inv; tbl_zero = z;
    @(negedge clk);
    tbl_we = 0;
    sv[sel] = v; skey[sel] = 5'(key); spreg[sel] = 5'(preg);
    sinv[sel] = inv; szero[sel] = z;
  endtask

  task automatic run(input int rd, input int vl, input bit poke, input string req);
    bit hit = 0, z = 0;
    logic [4:0] pr = '0;
    logic [31:0] m;
    int n = (vl > 32) ? 32 : vl;
    for (int i = 0; i < 16; i++)
      if (sv[i] && skey[i] == 5'(rd)) begin hit = 1; pr = spreg[i]; z = szero[i];
        m = sinv[i] ? ~iregs[spreg[i]] : iregs[spreg[i]]; end
    if (!hit) m = '1;
    @(negedge clk);
    start = 1; start_rd = 5'(rd); start_vl = 6'(vl);
    #1;
    if (hit) chk(mask_raddr == pr, "R1", "mask_raddr", mask_raddr, pr);
    @(negedge clk);
    start = 0;
    if (n == 0) begin
      chk(!busy && !iss_valid, req, "busy after zero length", busy, 0);
      return;
    end
    for (int k = 0; k < n; k++) begin
      if (poke && k == 3) begin start = 0; tbl_we = 0; end
      chk(iss_valid && busy, req, "valid", iss_valid, 1);
      chk(iss_idx == 5'(k), req, "idx", iss_idx, k);
      chk(iss_en == m[k], req, "en", iss_en, m[k]);
      chk(iss_zero == (z && !m[k]), req, "zero", iss_zero, z && !m[k]);
      if (poke && k == 2) begin
        start = 1; start_rd = 5'd3; start_vl = 6'd2;
        tbl_we = 1; tbl_sel = 4'd1; tbl_valid = 1; tbl_key = 5'(rd);
        tbl_preg = 5'd13; tbl_inv = 0; tbl_zero = 0;
      end
      @(negedge clk);
    end
    if (poke) begin
      sv[1] = 1; skey[1] = 5'(rd); spreg[1] = 5'd13; sinv[1] = 0; szero[1] = 0;
    end
    chk(!busy && !iss_valid, req, "busy end", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) iregs[i] = 32'(i) * 32'h01010101 ^ 32'h5A3C_96E1;
    iregs[10] = 32'h0000_00A5; iregs[11] = 32'h0000_0036;
    iregs[12] = 32'hFFFF_FF0F; iregs[13] = 32'h0000_0000;
    for (int i = 0; i < 16; i++) begin
      sv[i] = 0; sinv[i] = 0; szero[i] = 0; skey[i] = '0; spreg[i] = '0;
    end
    repeat (2) @(negedge clk);
    chk(!busy && !iss_valid && !iss_en && !iss_zero, "R10", "reset outputs", busy, 0);
    rst_n = 1;
    run(4, 7, 0, "R10");           // empty table after reset: all enabled
    run(3, 5, 0, "R5");
    wr(0, 1, 4, 10, 0, 0);
    run(4, 8, 0, "R4");            // A5 -> 1,0,1,0,0,1,0,1 skip mode
    wr(1, 1, 5, 11, 1, 1);
    run(5, 6, 0, "R2");            // inverted 36 with zeroing
    run(5, 8, 0, "R3");
    wr(7, 1, 4, 12, 0, 1);
    run(4, 10, 0, "R6");           // entry 7 beats entry 0
    wr(7, 0, 4, 12, 0, 1);
    run(4, 8, 0, "R6");            // invalid entry 7 no longer matches
    run(9, 40, 0, "R7");           // clamp to 32
    run(9, 0, 0, "R7");
    run(5, 6, 1, "R9");            // restart and table rewrite mid-loop: R8 too
    run(5, 6, 0, "R8");            // the rewrite takes effect on the next loop
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule